// File: doc/BRIEF.md
# Stack Transfer and Return Sequencer

This block carries out the multi-access stack operations of an 8-bit accumulator CPU: the software trap (break) entry, the return from an interrupt, the return from a subroutine, and pushing or pulling the status byte or the accumulator. It owns the 8-bit stack pointer and drives a single-port byte memory, one access per clock. The stack always sits in memory page 0x01.

The surrounding core fetches and decodes the instruction, then pulses `start_i` with a 3-bit operation code together with its current program counter, status byte and accumulator. The block runs the fixed access sequence for that operation, then pulses `done_o` for one clock. On that clock the new program counter, status, accumulator and stack pointer stand on its outputs, with the number of CPU cycles the operation is accounted at. Values an operation does not change pass through from the inputs given at start and hold until the next accepted start.

Top module: `stack_seq`

## Requirements
- R1: A push writes to address 0x0100 + SP and then decrements SP. A pull first increments SP and then reads address 0x0100 + SP. Every write lands in page 0x01.
- R2: SP wraps modulo 256 in both directions: a pull at SP=0xFF reads 0x0100 and leaves SP=0x00, and a push at SP=0x00 writes 0x0100 and leaves SP=0xFF.
- R3: Operation code 0 (trap entry) uses PC+2 and writes its high byte, then its low byte, then the status byte with bit 4 set, in three successive pushes. It then reads the new PC low byte from 0xFFFE and the high byte from 0xFFFF. The resulting status has bits 4 and 2 set, and the cycle count is 7.
- R4: Operation code 1 (interrupt return) pulls the status byte unmodified, then PC low, then PC high. The cycle count is 6.
- R5: Operation code 2 (subroutine return) pulls PC low, then PC high, and outputs that value plus 1, wrapping at 16 bits. The cycle count is 6.
- R6: Operation code 3 pushes the status byte with bit 4 forced to 0 and has a cycle count of 3. Operation code 4 loads status from the pulled byte with bit 4 forced to 0 and has a cycle count of 4.
- R7: Operation code 5 pushes the accumulator, with a cycle count of 3. Operation code 6 loads the accumulator from the pulled byte, sets status bit 1 when that byte is zero and copies its bit 7 into status bit 7, leaving the other status bits unchanged. Its cycle count is 4.
- R8: The first memory access is presented in the clock after the start is sampled, with one access per clock after that. `done_o` is high for exactly one clock, immediately after the last access, and no access occurs while it is high.
- R9: A start that arrives while an operation is in progress, or a start with operation code 7, has no effect: it causes no memory access and no done pulse, and leaves SP and the outputs unchanged.
- R10: After reset SP is 0xFF, `busy_o`, `done_o` and `mem_en_o` are low, and the cycle count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| op_i | input | 3 | Operation code (0 trap, 1 interrupt return, 2 subroutine return, 3 push status, 4 pull status, 5 push accumulator, 6 pull accumulator) |
| pc_i | input | 16 | Program counter at start |
| status_i | input | 8 | Status byte at start |
| acc_i | input | 8 | Accumulator at start |
| mem_addr_o | output | 16 | Memory address of the current access |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | Write enable |
| mem_en_o | output | 1 | Access valid this clock |
| mem_rdata_i | input | 8 | Read data for the current address, same clock |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock completion pulse |
| cycles_o | output | 4 | CPU cycle count of the last accepted operation |
| pc_o | output | 16 | Resulting program counter |
| status_o | output | 8 | Resulting status byte |
| acc_o | output | 8 | Resulting accumulator |
| sp_o | output | 8 | Stack pointer |

## Verification
The stack pointer can only be moved through pushes and pulls. The wrap at the page edge is therefore reached by issuing a pull straight out of reset, where SP is 0xFF, and then a push at SP 0x00. A start arriving mid-sequence is produced by pulsing the strobe two clocks into a five-access trap entry. The bench then confirms that the write stream and the single done pulse are those of the trap alone. Return values of 0xFFFF are staged with two accumulator pushes, so that the subroutine return shows the 16-bit wrap of its +1.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 2 * DATA_W;
  localparam int STEP_W = 3;
  localparam int CYC_W  = 4;

  // status bit positions
  localparam int FLAG_Z = 1;
  localparam int FLAG_I = 2;
  localparam int FLAG_B = 4;
  localparam int FLAG_N = 7;

  localparam logic [DATA_W-1:0] B_MASK = DATA_W'(1) << FLAG_B;
  localparam logic [DATA_W-1:0] I_MASK = DATA_W'(1) << FLAG_I;

  typedef enum logic [2:0] {
    OP_TRAP  = 3'd0,
    OP_IRET  = 3'd1,
    OP_SRET  = 3'd2,
    OP_PUSHS = 3'd3,
    OP_PULLS = 3'd4,
    OP_PUSHA = 3'd5,
    OP_PULLA = 3'd6,
    OP_NONE  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    AK_PUSH = 2'd0,
    AK_PULL = 2'd1,
    AK_VLO  = 2'd2,
    AK_VHI  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    WS_PCH       = 3'd0,
    WS_PCL       = 3'd1,
    WS_STAT      = 3'd2,
    WS_STAT_CLRB = 3'd3,
    WS_ACC       = 3'd4
  } wsel_e;

  typedef enum logic [2:0] {
    RD_NONE      = 3'd0,
    RD_STAT      = 3'd1,
    RD_STAT_CLRB = 3'd2,
    RD_PCL       = 3'd3,
    RD_PCH       = 3'd4,
    RD_ACC       = 3'd5
  } rdst_e;

  typedef struct packed {
    kind_e kind;
    wsel_e wsel;
    rdst_e rdst;
    logic  last;
  } step_t;

  function automatic logic [CYC_W-1:0] cycles_of(op_e op);
    case (op)
      OP_TRAP:            return CYC_W'(7);
      OP_IRET, OP_SRET:   return CYC_W'(6);
      OP_PUSHS, OP_PUSHA: return CYC_W'(3);
      OP_PULLS, OP_PULLA: return CYC_W'(4);
      default:            return CYC_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/stack_seq_plan.sv
// Step decoder: what each access of each operation does.
module stack_seq_plan
  import stack_seq_pkg::*;
(
  input  op_e               op,
  input  logic [STEP_W-1:0] step,
  output step_t             st
);

  always_comb begin
    st.kind = AK_PULL;
    st.wsel = WS_ACC;
    st.rdst = RD_NONE;
    st.last = 1'b1;
    case (op)
      OP_TRAP: begin
        case (step)
          3'd0: begin st.kind = AK_PUSH; st.wsel = WS_PCH;  st.last = 1'b0; end
          3'd1: begin st.kind = AK_PUSH; st.wsel = WS_PCL;  st.last = 1'b0; end
          3'd2: begin st.kind = AK_PUSH; st.wsel = WS_STAT; st.last = 1'b0; end
          3'd3: begin st.kind = AK_VLO;  st.rdst = RD_PCL;  st.last = 1'b0; end
          default: begin st.kind = AK_VHI; st.rdst = RD_PCH; end
        endcase
      end
      OP_IRET: begin
        case (step)
          3'd0: begin st.rdst = RD_STAT; st.last = 1'b0; end
          3'd1: begin st.rdst = RD_PCL;  st.last = 1'b0; end
          default: st.rdst = RD_PCH;
        endcase
      end
      OP_SRET: begin
        if (step == 3'd0) begin
          st.rdst = RD_PCL;
          st.last = 1'b0;
        end else begin
          st.rdst = RD_PCH;
        end
      end
      OP_PUSHS: begin st.kind = AK_PUSH; st.wsel = WS_STAT_CLRB; end
      OP_PULLS: st.rdst = RD_STAT_CLRB;
      OP_PUSHA: begin st.kind = AK_PUSH; st.wsel = WS_ACC; end
      OP_PULLA: st.rdst = RD_ACC;
      default: ;
    endcase
  end

endmodule

// File: rtl/stack_seq_agu.sv
// Address generator: owns the stack pointer and the registered memory request.
module stack_seq_agu
  import stack_seq_pkg::*;
#(
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [ADDR_W-1:0] VEC_ADDR   = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  kind_e             kind,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_en,
  output logic [DATA_W-1:0] sp
);

  logic [DATA_W-1:0] sp_q, sp_n, sp_inc, sp_dec;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] wd_q, wd_n;
  logic              we_q, we_n, en_q, en_n;

  assign sp_inc = sp_q + DATA_W'(1);
  assign sp_dec = sp_q - DATA_W'(1);

  always_comb begin
    sp_n   = sp_q;
    addr_n = addr_q;
    wd_n   = wd_q;
    we_n   = 1'b0;
    en_n   = 1'b0;
    if (issue) begin
      en_n = 1'b1;
      case (kind)
        AK_PUSH: begin
          addr_n = {STACK_PAGE, sp_q};
          wd_n   = wdata;
          we_n   = 1'b1;
          sp_n   = sp_dec;
        end
        AK_PULL: begin
          addr_n = {STACK_PAGE, sp_inc};
          sp_n   = sp_inc;
        end
        AK_VLO:  addr_n = VEC_ADDR;
        default: addr_n = VEC_ADDR + ADDR_W'(1);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q   <= '1;
      addr_q <= '0;
      wd_q   <= '0;
      we_q   <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      sp_q   <= sp_n;
      addr_q <= addr_n;
      wd_q   <= wd_n;
      we_q   <= we_n;
      en_q   <= en_n;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wd_q;
  assign mem_we    = we_q;
  assign mem_en    = en_q;
  assign sp        = sp_q;

endmodule

// File: rtl/stack_seq_result.sv
// Result registers: seeded at start, updated by reads, finalised on the last access.
module stack_seq_result
  import stack_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] seed_pc,
  input  logic [DATA_W-1:0] seed_status,
  input  logic [DATA_W-1:0] seed_acc,
  input  logic              cap_en,
  input  rdst_e             rdst,
  input  logic [DATA_W-1:0] rdata,
  input  logic              fin_en,
  input  op_e               op,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] acc
);

  logic [ADDR_W-1:0] pc_q, pc_n;
  logic [DATA_W-1:0] st_q, st_n, acc_q, acc_n;
  logic              upd_en;

  assign upd_en = load | cap_en;

  always_comb begin
    pc_n  = pc_q;
    st_n  = st_q;
    acc_n = acc_q;
    if (load) begin
      pc_n  = seed_pc;
      st_n  = seed_status;
      acc_n = seed_acc;
    end else begin
      if (cap_en) begin
        case (rdst)
          RD_STAT:      st_n = rdata;
          RD_STAT_CLRB: st_n = rdata & ~B_MASK;
          RD_PCL:       pc_n[DATA_W-1:0] = rdata;
          RD_PCH:       pc_n[ADDR_W-1:DATA_W] = rdata;
          RD_ACC:       acc_n = rdata;
          default: ;
        endcase
      end
      if (fin_en) begin
        case (op)
          OP_TRAP: st_n = st_n | I_MASK;
          OP_SRET: pc_n = pc_n + ADDR_W'(1);
          OP_PULLA: begin
            st_n[FLAG_Z] = (acc_n == '0);
            st_n[FLAG_N] = acc_n[DATA_W-1];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      st_q  <= '0;
      acc_q <= '0;
    end else if (upd_en) begin
      pc_q  <= pc_n;
      st_q  <= st_n;
      acc_q <= acc_n;
    end
  end

  assign pc     = pc_q;
  assign status = st_q;
  assign acc    = acc_q;

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_ADDR   = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [2:0]  op_i,
  input  logic [15:0] pc_i,
  input  logic [7:0]  status_i,
  input  logic [7:0]  acc_i,
  output logic [15:0] mem_addr_o,
  output logic [7:0]  mem_wdata_o,
  output logic        mem_we_o,
  output logic        mem_en_o,
  input  logic [7:0]  mem_rdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [3:0]  cycles_o,
  output logic [15:0] pc_o,
  output logic [7:0]  status_o,
  output logic [7:0]  acc_o,
  output logic [7:0]  sp_o
);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_RUN = 2'd1, S_DONE = 2'd2} state_e;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  state_e            state_q, state_n;
  logic [STEP_W-1:0] step_q, step_n, plan_step;
  op_e               op_q, op_n, cur_op, op_in;
  rdst_e             rdst_q, rdst_n;
  logic              last_q, last_n;
  logic [CYC_W-1:0]  cyc_q, cyc_n;
  logic              ctl_en;

  logic              accept, issue, cap_en, fin_en;
  step_t             plan;
  logic [ADDR_W-1:0] seed_pc, res_pc, w_pc;
  logic [DATA_W-1:0] seed_st, res_st, w_st, res_acc, w_acc, wdata;

  assign op_in  = op_e'(op_i);
  assign accept = (state_q == S_IDLE) && start_i && (op_in != OP_NONE);
  assign cur_op = accept ? op_in : op_q;
  assign plan_step = accept ? '0 : step_q + STEP_W'(1);
  assign issue  = accept || ((state_q == S_RUN) && !last_q);
  assign cap_en = (state_q == S_RUN);
  assign fin_en = (state_q == S_RUN) && last_q;

  stack_seq_plan u_plan (
    .op   (cur_op),
    .step (plan_step),
    .st   (plan)
  );

  // start values; a trap advances PC by 2 and marks the break bit
  assign seed_pc = (op_in == OP_TRAP) ? pc_i + ADDR_W'(2) : pc_i;
  assign seed_st = (op_in == OP_TRAP) ? (status_i | B_MASK) : status_i;

  assign w_pc  = (state_q == S_IDLE) ? seed_pc  : res_pc;
  assign w_st  = (state_q == S_IDLE) ? seed_st  : res_st;
  assign w_acc = (state_q == S_IDLE) ? acc_i    : res_acc;

  always_comb begin
    case (plan.wsel)
      WS_PCH:       wdata = w_pc[ADDR_W-1:DATA_W];
      WS_PCL:       wdata = w_pc[DATA_W-1:0];
      WS_STAT:      wdata = w_st;
      WS_STAT_CLRB: wdata = w_st & ~B_MASK;
      default:      wdata = w_acc;
    endcase
  end

  stack_seq_agu #(
    .STACK_PAGE (STACK_PAGE),
    .VEC_ADDR   (VEC_ADDR)
  ) u_agu (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .issue     (issue),
    .kind      (plan.kind),
    .wdata     (wdata),
    .mem_addr  (mem_addr_o),
    .mem_wdata (mem_wdata_o),
    .mem_we    (mem_we_o),
    .mem_en    (mem_en_o),
    .sp        (sp_o)
  );

  stack_seq_result u_res (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .load        (accept),
    .seed_pc     (seed_pc),
    .seed_status (seed_st),
    .seed_acc    (acc_i),
    .cap_en      (cap_en),
    .rdst        (rdst_q),
    .rdata       (mem_rdata_i),
    .fin_en      (fin_en),
    .op          (op_q),
    .pc          (res_pc),
    .status      (res_st),
    .acc         (res_acc)
  );

  // sequencing next state
  always_comb begin
    state_n = state_q;
    step_n  = step_q;
    op_n    = op_q;
    rdst_n  = rdst_q;
    last_n  = last_q;
    cyc_n   = cyc_q;
    case (state_q)
      S_IDLE: begin
        if (accept) begin
          state_n = S_RUN;
          step_n  = '0;
          op_n    = op_in;
          rdst_n  = plan.rdst;
          last_n  = plan.last;
          cyc_n   = cycles_of(op_in);
        end
      end
      S_RUN: begin
        if (last_q) begin
          state_n = S_DONE;
        end else begin
          step_n = plan_step;
          rdst_n = plan.rdst;
          last_n = plan.last;
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  assign ctl_en = accept || (state_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      op_q    <= OP_NONE;
      rdst_q  <= RD_NONE;
      last_q  <= 1'b0;
      cyc_q   <= '0;
    end else if (ctl_en) begin
      state_q <= state_n;
      step_q  <= step_n;
      op_q    <= op_n;
      rdst_q  <= rdst_n;
      last_q  <= last_n;
      cyc_q   <= cyc_n;
    end
  end

  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = (state_q == S_DONE);
  assign cycles_o = cyc_q;
  assign pc_o     = res_pc;
  assign status_o = res_st;
  assign acc_o    = res_acc;

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_ADDR   = 16'hFFFE
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] mem_addr_o,
  input logic        mem_we_o,
  input logic        mem_en_o,
  input logic        busy_o,
  input logic        done_o,
  input logic [3:0]  cycles_o,
  input logic [7:0]  sp_o
);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_en_o);

  // R1
  write_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && mem_we_o) |-> (mem_addr_o[15:8] == STACK_PAGE));

  // R3
  read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && !mem_we_o) |->
      ((mem_addr_o[15:8] == STACK_PAGE) || (mem_addr_o[15:1] == VEC_ADDR[15:1])));

  // R2
  sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp_o) |->
      ((sp_o == 8'($past(sp_o) + 8'd1)) || (sp_o == 8'($past(sp_o) - 8'd1))));

  // R9
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(cycles_o));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_en_o);

endmodule

bind stack_seq stack_seq_chk #(
  .STACK_PAGE (STACK_PAGE),
  .VEC_ADDR   (VEC_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_addr_o (mem_addr_o),
  .mem_we_o   (mem_we_o),
  .mem_en_o   (mem_en_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .cycles_o   (cycles_o),
  .sp_o       (sp_o)
);

// File: tb/stack_seq_test.sv
module stack_seq_test;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] addr;
    logic [7:0]  data;
    string       tag;
  } wr_t;

  typedef struct {
    logic [15:0] pc;
    logic [7:0]  st;
    logic [7:0]  ac;
    logic [7:0]  sp;
    logic [3:0]  cyc;
    string       tag;
  } res_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [15:0] pc_i = 16'h0;
  logic [7:0]  status_i = 8'h0;
  logic [7:0]  acc_i = 8'h0;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        mem_we_o, mem_en_o;
  logic [7:0]  mem_rdata_i;
  logic        busy_o, done_o;
  logic [3:0]  cycles_o;
  logic [15:0] pc_o;
  logic [7:0]  status_o, acc_o, sp_o;

  logic [7:0] stk [256];
  logic [7:0] mdl [256];
  logic [7:0] vlo = 8'h34;
  logic [7:0] vhi = 8'hC2;
  logic [7:0] msp = 8'hFF;

  wr_t  wq[$];
  res_t rq[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .pc_i(pc_i),
    .status_i(status_i), .acc_i(acc_i), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o), .mem_en_o(mem_en_o),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o),
    .cycles_o(cycles_o), .pc_o(pc_o), .status_o(status_o), .acc_o(acc_o),
    .sp_o(sp_o)
  );

  // memory model: page 1 plus the two vector bytes, combinational read
  always_comb begin
    if (mem_addr_o[15:8] == 8'h01) mem_rdata_i = stk[mem_addr_o[7:0]];
    else if (mem_addr_o == 16'hFFFE) mem_rdata_i = vlo;
    else if (mem_addr_o == 16'hFFFF) mem_rdata_i = vhi;
    else mem_rdata_i = 8'h00;
  end

  always @(posedge clk) begin
    if (mem_en_o && mem_we_o && mem_addr_o[15:8] == 8'h01)
      stk[mem_addr_o[7:0]] <= mem_wdata_o;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: write stream
  always @(negedge clk) begin
    if (rst_n && mem_en_o && mem_we_o) begin
      if (wq.size() == 0) begin
        chk(1'b0, "R1", "unexpected write addr", mem_addr_o, 16'h0);
      end else begin
        wr_t e;
        e = wq.pop_front();
        chk(mem_addr_o == e.addr, e.tag, "write address", mem_addr_o, e.addr);
        chk(mem_wdata_o == e.data, e.tag, "write data", {8'h0, mem_wdata_o}, {8'h0, e.data});
      end
    end
  end

  // monitor: results on done
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (rq.size() == 0) begin
        chk(1'b0, "R9", "unexpected done", 16'h1, 16'h0);
      end else begin
        res_t e;
        e = rq.pop_front();
        chk(pc_o == e.pc, e.tag, "pc", pc_o, e.pc);
        chk(status_o == e.st, e.tag, "status", {8'h0, status_o}, {8'h0, e.st});
        chk(acc_o == e.ac, e.tag, "acc", {8'h0, acc_o}, {8'h0, e.ac});
        chk(sp_o == e.sp, e.tag, "sp", {8'h0, sp_o}, {8'h0, e.sp});
        chk(cycles_o == e.cyc, e.tag, "cycles", {12'h0, cycles_o}, {12'h0, e.cyc});
      end
    end
  end

  function automatic void m_push(input logic [7:0] d, input string tag);
    wq.push_back('{{8'h01, msp}, d, tag});
    mdl[msp] = d;
    msp = msp - 8'd1;
  endfunction

  function automatic logic [7:0] m_pull();
    msp = msp + 8'd1;
    return mdl[msp];
  endfunction

  // driver: predicts, queues expectations, runs one operation
  task automatic run_op(input logic [2:0] op, input logic [15:0] pc,
                        input logic [7:0] st, input logic [7:0] ac,
                        input string tag, input bit inject);
    logic [15:0] e_pc, p2;
    logic [7:0]  e_st, e_ac, lo, hi;
    logic [3:0]  cyc;
    int n, k;
    e_pc = pc; e_st = st; e_ac = ac; n = 1; cyc = 4'd0;
    case (op)
      3'd0: begin
        p2 = pc + 16'd2;
        m_push(p2[15:8], tag); m_push(p2[7:0], tag); m_push(st | 8'h10, tag);
        e_st = st | 8'h14; e_pc = {vhi, vlo}; n = 5; cyc = 4'd7;
      end
      3'd1: begin
        e_st = m_pull(); lo = m_pull(); hi = m_pull();
        e_pc = {hi, lo}; n = 3; cyc = 4'd6;
      end
      3'd2: begin
        lo = m_pull(); hi = m_pull();
        e_pc = {hi, lo} + 16'd1; n = 2; cyc = 4'd6;
      end
      3'd3: begin m_push(st & 8'hEF, tag); cyc = 4'd3; end
      3'd4: begin e_st = m_pull() & 8'hEF; cyc = 4'd4; end
      3'd5: begin m_push(ac, tag); cyc = 4'd3; end
      default: begin
        e_ac = m_pull();
        e_st = (st & 8'h7D) | ((e_ac == 8'h00) ? 8'h02 : 8'h00) | (e_ac & 8'h80);
        cyc = 4'd4;
      end
    endcase
    rq.push_back('{e_pc, e_st, e_ac, msp, cyc, tag});
    start_i = 1'b1; op_i = op; pc_i = pc; status_i = st; acc_i = ac;
    @(negedge clk);
    start_i = 1'b0;
    k = 1;
    while (!done_o && k < 20) begin
      if (inject && k == 2) begin
        start_i = 1'b1; op_i = 3'd5; acc_i = 8'hE7;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start_i = 1'b0;
    // R8: done arrives the clock after the n-th access
    chk(k == n + 1, "R8", "clocks to done", 16'(k), 16'(n + 1));
    @(negedge clk);
    chk(!done_o, "R8", "done width", {15'h0, done_o}, 16'h0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      stk[i] = 8'h00;
      mdl[i] = 8'h00;
    end
    stk[0] = 8'h77;
    mdl[0] = 8'h77;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk(sp_o == 8'hFF, "R10", "sp", {8'h0, sp_o}, 16'h00FF);
    chk(!busy_o && !done_o && !mem_en_o, "R10", "busy/done/en",
        {13'h0, busy_o, done_o, mem_en_o}, 16'h0);
    chk(cycles_o == 4'd0, "R10", "cycles", {12'h0, cycles_o}, 16'h0);

    // R2 wrap: pull at 0xFF reads 0x0100, push at 0x00 writes 0x0100
    run_op(3'd6, 16'h0200, 8'h00, 8'h11, "R2", 1'b0);
    run_op(3'd5, 16'h0200, 8'h00, 8'h5A, "R2", 1'b0);
    chk(stk[0] == 8'h5A, "R2", "byte at 0x0100", {8'h0, stk[0]}, 16'h005A);

    // R1 / R6 / R7 single-byte transfers
    run_op(3'd5, 16'h0300, 8'h01, 8'h93, "R1", 1'b0);
    run_op(3'd4, 16'h0300, 8'h00, 8'h00, "R6", 1'b0);
    run_op(3'd3, 16'h0300, 8'hFF, 8'h00, "R6", 1'b0);
    run_op(3'd6, 16'h0300, 8'h02, 8'h00, "R7", 1'b0);
    run_op(3'd5, 16'h0300, 8'h80, 8'h00, "R7", 1'b0);
    run_op(3'd6, 16'h0300, 8'h80, 8'h5F, "R7", 1'b0);

    // R3 trap entry, with a start injected mid-sequence (R9)
    run_op(3'd0, 16'h12FE, 8'h00, 8'h21, "R3", 1'b1);
    chk(wq.size() == 0, "R9", "writes left", 16'(wq.size()), 16'h0);

    // R4 interrupt return undoes the trap
    run_op(3'd1, 16'h0000, 8'hAA, 8'h00, "R4", 1'b0);

    // R5 subroutine return, plain and wrapping
    run_op(3'd5, 16'h0000, 8'h00, 8'h40, "R5", 1'b0);
    run_op(3'd5, 16'h0000, 8'h00, 8'hFF, "R5", 1'b0);
    run_op(3'd2, 16'h0000, 8'h00, 8'h00, "R5", 1'b0);
    run_op(3'd5, 16'h0000, 8'h00, 8'hFF, "R5", 1'b0);
    run_op(3'd5, 16'h0000, 8'h00, 8'hFF, "R5", 1'b0);
    run_op(3'd2, 16'h0000, 8'h00, 8'h00, "R5", 1'b0);

    // R9 operation code 7 is ignored
    start_i = 1'b1; op_i = 3'd7; acc_i = 8'h3C;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(!mem_en_o && !done_o && !busy_o, "R9", "activity after code 7",
          {13'h0, mem_en_o, done_o, busy_o}, 16'h0);
      @(negedge clk);
    end
    chk(sp_o == msp, "R9", "sp after code 7", {8'h0, sp_o}, {8'h0, msp});
    chk(rq.size() == 0 && wq.size() == 0, "R8", "pending expectations",
        16'(rq.size() + wq.size()), 16'h0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule